// File: doc/BRIEF.md
# Performance Counter Register Bank

The block is a small performance-monitoring unit that software reaches through a single-cycle register port. It holds one free-running 32-bit clock-cycle counter and three 32-bit event counters. Each event counter is paired with an event-selection register that names one of the event input lines. Software picks which pair it addresses by writing an index into a counter-index register. The event-selection and event-count windows are then indirect views of the pair that the index names.

Every request is checked against the caller's privilege level and a user-enable bit. A request that is refused returns zero, changes nothing and raises a one-cycle error flag. The cycle counter can be loaded only while it is stopped. A load attempted while it runs is refused in the same way, and the counter carries on counting.

Register map (3-bit address): 0 control (bit 0 enables the event counters, bit 1 enables the cycle counter), 1 counter index, 2 cycle counter, 3 event-selection window, 4 event-count window, 5 user-enable (bit 0), 6 and 7 unused.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset, every counter, every event selection, the index, the control bits and the user-enable bit are zero, and `rsp_rdata` and `acc_err` are low.
- R2: The counter-index register keeps write-data bits [4:0]. Its bits [31:5] read as zero, whatever was written to them.
- R3: Index values 0, 1 and 2 make addresses 3 and 4 reach event-selection register and event counter 0, 1 or 2. Event-selection registers keep bits [4:0] and read zero above them.
- R4: With an index of 3 or more, reads of addresses 3 and 4 return zero, writes to them are dropped, and no error is raised.
- R5: The cycle counter adds one on every clock while control bit 1 is set, and holds its value while that bit is clear.
- R6: A write to address 2 while control bit 1 is clear loads the cycle counter. The same write while bit 1 is set is ignored, the counter keeps counting, and `acc_err` is raised.
- R7: Event counter i adds one on every clock in which control bit 0 is set and `ev_in[evsel_i]` is high. It does not change while bit 0 is clear.
- R8: A privileged request (`priv_mode`=1) to any address is granted, except for the running-counter write covered by R6.
- R9: In user mode with the user-enable bit clear, any access to addresses 0 to 4 returns zero, changes no state and raises `acc_err`. With the bit set, these accesses behave as they do in privileged mode.
- R10: The user-enable register reads in both modes, but only a privileged write changes it. A user-mode write to it is refused with `acc_err`.
- R11: All counters are 32 bits wide and wrap from 0xFFFFFFFF to zero.
- R12: `rsp_rdata` and `acc_err` appear on the clock after the request and show register values from before that clock's update. `rsp_rdata` is zero when there is no granted read, and addresses 6 and 7 read as zero without an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_mode | input | 1 | 1 = privileged caller, 0 = user caller |
| req_valid | input | 1 | Register request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register address |
| req_wdata | input | 32 | Write data |
| ev_in | input | 32 | Event input lines, level-counted per clock |
| rsp_rdata | output | 32 | Read data, one clock after the request |
| acc_err | output | 1 | One-cycle refused-access flag |

## Verification
On every cycle, the assertions check the per-clock step and hold rules of the cycle counter and of each event counter. They also check that a privileged request raises no error unless it loads a running counter, that a refused access returns zero, and that the response lines fall to zero on idle cycles. Three things only the bench scenarios can show: that the indirect index reaches the right pair, that a refused user write really leaves the register unchanged when it is read back, and that the counters wrap.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int DW = 32;
  localparam int AW = 3;

  typedef enum logic [AW-1:0] {
    REG_CTRL   = 3'd0,
    REG_INDEX  = 3'd1,
    REG_CYCLE  = 3'd2,
    REG_EVSEL  = 3'd3,
    REG_EVCNT  = 3'd4,
    REG_USEREN = 3'd5
  } pmu_reg_e;

  function automatic logic [DW-1:0] step_wrap(input logic [DW-1:0] v);
    return v + 1'b1;
  endfunction

  function automatic logic gated_addr(input logic [AW-1:0] a);
    return a <= REG_EVCNT;
  endfunction
endpackage

// File: rtl/pmu_access_gate.sv
module pmu_access_gate
  import pmu_pkg::*;
#(
  parameter int NUM_CNT = 3,
  parameter int SEL_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [AW-1:0]      req_addr,
  input  logic               priv_mode,
  input  logic               user_en,
  input  logic               cyc_running,
  input  logic [SEL_W-1:0]   sel_idx,
  output logic               wr_ctrl,
  output logic               wr_index,
  output logic               wr_cycle,
  output logic               wr_useren,
  output logic [NUM_CNT-1:0] wr_evsel,
  output logic [NUM_CNT-1:0] wr_evcnt,
  output logic               rd_en,
  output logic               deny
);
  logic user_block, cyc_block, grant, wr_go;

  always_comb begin
    user_block = !priv_mode &&
                 ((gated_addr(req_addr) && !user_en) ||
                  (req_addr == REG_USEREN && req_write));
    cyc_block  = req_write && req_addr == REG_CYCLE && cyc_running && !user_block;
    grant      = req_valid && !user_block;
    wr_go      = grant && req_write;
    deny       = req_valid && (user_block || cyc_block);
    rd_en      = grant && !req_write;
    wr_ctrl    = wr_go && req_addr == REG_CTRL;
    wr_index   = wr_go && req_addr == REG_INDEX;
    wr_cycle   = wr_go && req_addr == REG_CYCLE && !cyc_running;
    wr_useren  = wr_go && req_addr == REG_USEREN;
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_slot
    always_comb begin
      wr_evsel[i] = wr_go && req_addr == REG_EVSEL && sel_idx == SEL_W'(i);
      wr_evcnt[i] = wr_go && req_addr == REG_EVCNT && sel_idx == SEL_W'(i);
    end
  end

  // R8: a privileged caller is refused only for a running-counter load
  a_r8_priv_granted: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && priv_mode && !(req_write && req_addr == REG_CYCLE && cyc_running)) |-> !deny);
  // R9: a refused user access produces no write strobe
  a_r9_denied_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !priv_mode && !user_en && req_addr <= REG_EVCNT) |->
      !(wr_ctrl || wr_index || wr_cycle || (|wr_evsel) || (|wr_evcnt)));
  a_r3_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_evsel) && $onehot0(wr_evcnt));
endmodule

// File: rtl/pmu_cycle_counter.sv
module pmu_cycle_counter
  import pmu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  output logic [DW-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (run)  count <= step_wrap(count);
  end

  // R5 / R11: step by one with wrap while running
  a_r5_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load) |=> count == $past(count) + 32'd1);
  a_r5_cycle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(count));
endmodule

// File: rtl/pmu_event_counter.sv
module pmu_event_counter
  import pmu_pkg::*;
#(
  parameter int NUM_EVENTS = 32,
  localparam int EVSEL_W = (NUM_EVENTS > 1) ? $clog2(NUM_EVENTS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_EVENTS-1:0] ev_in,
  input  logic                  cnt_en,
  input  logic                  sel_wr,
  input  logic                  cnt_wr,
  input  logic [DW-1:0]         wdata,
  output logic [EVSEL_W-1:0]    evsel,
  output logic [DW-1:0]         count
);
  logic hit;

  always_comb begin
    hit = 1'b0;
    for (int e = 0; e < NUM_EVENTS; e++)
      if (evsel == EVSEL_W'(e)) hit = ev_in[e];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      evsel <= '0;
    else if (sel_wr) evsel <= wdata[EVSEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count <= '0;
    else if (cnt_wr)           count <= wdata;
    else if (cnt_en && hit)    count <= step_wrap(count);
  end

  // R7: one step per selected event cycle, otherwise hold
  a_r7_event_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && hit && !cnt_wr) |=> count == $past(count) + 32'd1);
  a_r7_event_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cnt_en && hit) && !cnt_wr) |=> $stable(count));
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import pmu_pkg::*;
#(
  parameter int NUM_CNT    = 3,
  parameter int NUM_EVENTS = 32,
  parameter int SEL_W      = 5,
  localparam int EVSEL_W   = (NUM_EVENTS > 1) ? $clog2(NUM_EVENTS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  priv_mode,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [AW-1:0]         req_addr,
  input  logic [DW-1:0]         req_wdata,
  input  logic [NUM_EVENTS-1:0] ev_in,
  output logic [DW-1:0]         rsp_rdata,
  output logic                  acc_err
);
  logic               evt_run, cyc_run, user_en;
  logic [SEL_W-1:0]   sel_idx;
  logic               wr_ctrl, wr_index, wr_cycle, wr_useren, rd_en, deny;
  logic [NUM_CNT-1:0] wr_evsel, wr_evcnt;
  logic [DW-1:0]      cyc_count;
  logic [EVSEL_W-1:0] evsel_q [NUM_CNT];
  logic [DW-1:0]      evcnt_q [NUM_CNT];
  logic [DW-1:0]      rd_val;

  pmu_access_gate #(.NUM_CNT(NUM_CNT), .SEL_W(SEL_W)) u_gate (
    .clk, .rst_n, .req_valid, .req_write, .req_addr, .priv_mode,
    .user_en, .cyc_running(cyc_run), .sel_idx,
    .wr_ctrl, .wr_index, .wr_cycle, .wr_useren, .wr_evsel, .wr_evcnt,
    .rd_en, .deny
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_run <= 1'b0;
      cyc_run <= 1'b0;
      user_en <= 1'b0;
      sel_idx <= '0;
    end else begin
      if (wr_ctrl)   {cyc_run, evt_run} <= req_wdata[1:0];
      if (wr_useren) user_en <= req_wdata[0];
      if (wr_index)  sel_idx <= req_wdata[SEL_W-1:0];
    end
  end

  pmu_cycle_counter u_cycle (
    .clk, .rst_n, .run(cyc_run), .load(wr_cycle), .load_val(req_wdata),
    .count(cyc_count)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_evt
    pmu_event_counter #(.NUM_EVENTS(NUM_EVENTS)) u_evt (
      .clk, .rst_n, .ev_in, .cnt_en(evt_run),
      .sel_wr(wr_evsel[i]), .cnt_wr(wr_evcnt[i]), .wdata(req_wdata),
      .evsel(evsel_q[i]), .count(evcnt_q[i])
    );
  end

  always_comb begin
    rd_val = '0;
    case (req_addr)
      REG_CTRL:   rd_val = {{(DW-2){1'b0}}, cyc_run, evt_run};
      REG_INDEX:  rd_val = {{(DW-SEL_W){1'b0}}, sel_idx};
      REG_CYCLE:  rd_val = cyc_count;
      REG_USEREN: rd_val = {{(DW-1){1'b0}}, user_en};
      REG_EVSEL, REG_EVCNT:
        for (int i = 0; i < NUM_CNT; i++)
          if (sel_idx == SEL_W'(i))
            rd_val = (req_addr == REG_EVSEL) ? {{(DW-EVSEL_W){1'b0}}, evsel_q[i]}
                                             : evcnt_q[i];
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
      acc_err   <= 1'b0;
    end else begin
      rsp_rdata <= rd_en ? rd_val : '0;
      acc_err   <= deny;
    end
  end

  // R9: a refused access never returns data
  a_r9_err_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> rsp_rdata == '0);
  // R12: idle cycle leaves the response quiet
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (rsp_rdata == '0 && !acc_err));
  // R6: a privileged load of a running counter is flagged
  a_r6_running_load_err: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && priv_mode && req_addr == REG_CYCLE && cyc_run) |=> acc_err);
  // R4: out-of-range index reads return zero
  a_r4_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && priv_mode && sel_idx >= SEL_W'(NUM_CNT) &&
     (req_addr == REG_EVSEL || req_addr == REG_EVCNT)) |=> rsp_rdata == '0);
endmodule

// File: tb/tb_perf_counter_bank.sv
module tb_perf_counter_bank;
  localparam int CLK_P = 10;
  localparam logic [2:0] A_CTRL = 0, A_IDX = 1, A_CYC = 2, A_SEL = 3, A_CNT = 4, A_UEN = 5;

  logic clk = 0, rst_n = 0, priv_mode = 1, req_valid = 0, req_write = 0;
  logic [2:0]  req_addr = 0;
  logic [31:0] req_wdata = 0, ev_in = 0;
  logic [31:0] rsp_rdata;
  logic        acc_err;
  int tests = 0, fails = 0;

  perf_counter_bank dut (.clk, .rst_n, .priv_mode, .req_valid, .req_write,
    .req_addr, .req_wdata, .ev_in, .rsp_rdata, .acc_err);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference state, updated from the requirements
  logic [1:0]  m_ctrl;
  logic [4:0]  m_idx;
  logic [31:0] m_cyc, m_rdata;
  logic [4:0]  m_sel [3];
  logic [31:0] m_cnt [3];
  logic        m_uen, m_err, m_chk;
  logic        m_den, m_grant;

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    case (a)
      A_CTRL: return {30'd0, m_ctrl};
      A_IDX:  return {27'd0, m_idx};
      A_CYC:  return m_cyc;
      A_UEN:  return {31'd0, m_uen};
      A_SEL:  return (m_idx < 3) ? {27'd0, m_sel[m_idx]} : 32'd0;
      A_CNT:  return (m_idx < 3) ? m_cnt[m_idx] : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  always_comb begin
    m_den = !priv_mode && ((req_addr <= A_CNT && !m_uen) || (req_addr == A_UEN && req_write));
    m_grant = req_valid && !m_den;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl <= 0; m_idx <= 0; m_cyc <= 0; m_uen <= 0;
      m_rdata <= 0; m_err <= 0; m_chk <= 0;
      for (int i = 0; i < 3; i++) begin m_sel[i] <= 0; m_cnt[i] <= 0; end
    end else begin
      m_chk   <= req_valid;
      m_rdata <= (m_grant && !req_write) ? exp_read(req_addr) : 32'd0;
      m_err   <= req_valid && (m_den || (req_write && req_addr == A_CYC && m_ctrl[1]));
      if (m_grant && req_write && req_addr == A_CYC && !m_ctrl[1]) m_cyc <= req_wdata;
      else if (m_ctrl[1]) m_cyc <= m_cyc + 1;
      for (int i = 0; i < 3; i++) begin
        if (m_grant && req_write && req_addr == A_CNT && m_idx == 5'(i)) m_cnt[i] <= req_wdata;
        else if (m_ctrl[0] && ev_in[m_sel[i]]) m_cnt[i] <= m_cnt[i] + 1;
        if (m_grant && req_write && req_addr == A_SEL && m_idx == 5'(i)) m_sel[i] <= req_wdata[4:0];
      end
      if (m_grant && req_write && req_addr == A_CTRL) m_ctrl <= req_wdata[1:0];
      if (m_grant && req_write && req_addr == A_IDX)  m_idx  <= req_wdata[4:0];
      if (m_grant && req_write && req_addr == A_UEN)  m_uen  <= req_wdata[0];
    end
  end

  always @(negedge clk) begin
    if (rst_n && m_chk) begin
      chk("R12 model rdata", rsp_rdata, m_rdata);
      chk("R9 model err", {31'd0, acc_err}, {31'd0, m_err});
    end
  end

  task automatic req(input bit w, input logic [2:0] a, input logic [31:0] d, input bit p);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d; priv_mode = p;
    @(negedge clk);
    req_valid = 0; req_write = 0; priv_mode = 1;
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] r1;
    repeat (3) @(negedge clk);
    chk("R1 rdata at reset", rsp_rdata, 0);
    chk("R1 err at reset", {31'd0, acc_err}, 0);
    rst_n = 1;
    req(0, A_CYC, 0, 1); chk("R1 cycle zero", rsp_rdata, 0);
    req(0, A_CNT, 0, 1); chk("R1 event count zero", rsp_rdata, 0);
    req(1, A_IDX, 32'hFFFF_FFE1, 1);
    req(0, A_IDX, 0, 1); chk("R2 index upper bits zero", rsp_rdata, 32'h1);
    for (int i = 0; i < 3; i++) begin
      req(1, A_IDX, i, 1); req(1, A_SEL, 32'hFFFF_FFE0 | (i + 3), 1);
    end
    for (int i = 0; i < 3; i++) begin
      req(1, A_IDX, i, 1); req(0, A_SEL, 0, 1);
      chk("R3 selection via index", rsp_rdata, i + 3);
    end
    req(1, A_IDX, 7, 1);
    req(0, A_SEL, 0, 1); chk("R4 out-of-range read", rsp_rdata, 0);
    req(1, A_CNT, 5, 1); chk("R4 out-of-range write no err", {31'd0, acc_err}, 0);
    for (int i = 0; i < 3; i++) begin
      req(1, A_IDX, i, 1); req(0, A_CNT, 0, 1);
      chk("R4 dropped write left counter", rsp_rdata, 0);
    end
    req(0, 3'd6, 0, 1); chk("R12 unused address reads zero", rsp_rdata, 0);
    req(1, A_CYC, 100, 1);
    req(0, A_CYC, 0, 1); chk("R6 load while stopped", rsp_rdata, 100);
    req(1, A_CTRL, 2, 1);
    req(0, A_CYC, 0, 1); r1 = rsp_rdata;
    repeat (4) @(negedge clk);
    req(0, A_CYC, 0, 1); chk("R5 counts each clock", rsp_rdata - r1, 6);
    req(1, A_CYC, 7, 1); chk("R6 running load flagged", {31'd0, acc_err}, 1);
    req(1, A_CTRL, 0, 1);
    req(0, A_CYC, 0, 1); r1 = rsp_rdata;
    repeat (3) @(negedge clk);
    req(0, A_CYC, 0, 1); chk("R5 holds when stopped", rsp_rdata, r1);
    chk("R6 ignored load did not land", {31'd0, r1 == 7}, 0);
    req(1, A_CYC, 32'hFFFF_FFFF, 1); req(1, A_CTRL, 2, 1); req(1, A_CTRL, 0, 1);
    req(0, A_CYC, 0, 1); chk("R11 cycle wraps", rsp_rdata, 1);
    req(1, A_IDX, 0, 1); req(1, A_CNT, 32'hFFFF_FFFF, 1); req(1, A_CTRL, 1, 1);
    @(negedge clk); ev_in = 32'h8; @(negedge clk); ev_in = 0;
    req(1, A_CTRL, 0, 1);
    req(0, A_CNT, 0, 1); chk("R11 event counter wraps", rsp_rdata, 0);
    req(1, A_IDX, 1, 1); req(1, A_CTRL, 1, 1);
    @(negedge clk); ev_in = 32'h30; repeat (5) @(negedge clk); ev_in = 0;
    req(1, A_CTRL, 0, 1);
    req(0, A_CNT, 0, 1); chk("R7 counts selected event", rsp_rdata, 5);
    @(negedge clk); ev_in = 32'h10; repeat (3) @(negedge clk); ev_in = 0;
    req(0, A_CNT, 0, 1); chk("R7 no count when disabled", rsp_rdata, 5);
    req(0, A_CYC, 0, 0); chk("R9 denied read zero", rsp_rdata, 0);
    chk("R9 denied read err", {31'd0, acc_err}, 1);
    req(1, A_IDX, 2, 0); chk("R9 denied write err", {31'd0, acc_err}, 1);
    req(0, A_IDX, 0, 1); chk("R9 denied write no change", rsp_rdata, 1);
    req(1, A_UEN, 1, 0); chk("R10 user write refused", {31'd0, acc_err}, 1);
    req(0, A_UEN, 0, 1); chk("R10 enable unchanged", rsp_rdata, 0);
    req(1, A_UEN, 1, 1);
    req(0, A_UEN, 0, 0); chk("R10 user read of enable", rsp_rdata, 1);
    req(0, A_IDX, 0, 0); chk("R9 permitted user read", rsp_rdata, 1);
    chk("R8 permitted no err", {31'd0, acc_err}, 0);
    void'($urandom(32'h5EED));
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      ev_in = $urandom;
      req_valid = ($urandom % 4) != 0;
      req_write = $urandom % 2;
      req_addr = $urandom % 8;
      priv_mode = ($urandom % 3) != 0;
      req_wdata = ($urandom % 2) ? ($urandom % 6) : $urandom;
    end
    @(negedge clk); req_valid = 0;
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule